// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. One short history of recent branch outcomes is shared by every branch. Each branch slot has its own small table of 2-bit saturating counters. The current history selects one counter in the table of the branch being asked about. That counter's upper bit is the guess.

A fetch stage presents a branch slot ID and reads the guess combinationally in the same cycle. When the branch resolves, the pipeline presents the slot ID, the real outcome and a valid strobe. On that clock edge the counter picked by the history is trained, and the outcome is shifted into the history. Because every slot has its own table, the same history value selects different counters for different branches.

Top module: `dir_pred_ghist`

## Requirements
- R1: After reset every history bit is 0 (not-taken) and every counter is strongly not-taken, so every in-range slot predicts not-taken.
- R2: The counter encoding is 00 strongly not-taken, 01 weakly not-taken, 10 weakly taken and 11 strongly taken. The prediction is the counter's upper bit, so it is taken for 10 and 11.
- R3: A valid update with outcome taken adds one to the selected counter, and the counter stays at 11 once it is there.
- R4: A valid update with outcome not-taken subtracts one from the selected counter, and the counter stays at 00 once it is there.
- R5: An update trains the counter at the index given by the history as it was before the update. After the update the history is {old_hist[0], outcome}: the outcome enters bit 0, and taken is written as 1.
- R6: The history is shared. An update to any in-range slot shifts it, which changes the counter that every slot reads next.
- R7: Each slot has its own table. An update to one slot leaves the counters of every other slot unchanged.
- R8: An update whose slot ID is NUM_SLOTS or higher is ignored: it changes neither the history nor any counter.
- R9: A prediction request whose slot ID is NUM_SLOTS or higher returns not-taken.
- R10: The prediction follows the slot ID and the current state with no clock delay. An update takes effect at the next rising clock edge. With the valid strobe low, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pred_id_i | input | ID_W | Slot ID of the branch to predict |
| pred_taken_o | output | 1 | Predicted direction, 1 means taken |
| upd_valid_i | input | 1 | Update strobe |
| upd_id_i | input | ID_W | Slot ID of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome, 1 means taken |

## Verification
The bench uses the default parameters: four slots, a 2-bit history and a 3-bit slot ID. Slot IDs 4 to 7 therefore exist on both ports and exercise the ignore and not-taken rules. The small history means that the outcomes themselves steer the counter index through all four entries of each table. Runs of equal outcomes therefore reach both saturation limits in only a few updates. After every update, a random or directed mix of updates is compared against a reference model of all sixteen counters and the history, across every slot ID.

// File: rtl/dir_pred_pkg.sv
package dir_pred_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_state_e;

  function automatic ctr_state_e ctr_next(ctr_state_e s, logic taken);
    ctr_state_e n;
    n = s;
    if (taken) begin
      if (s != CTR_ST) n = ctr_state_e'(2'(s) + 2'd1);
    end else begin
      if (s != CTR_SNT) n = ctr_state_e'(2'(s) - 2'd1);
    end
    return n;
  endfunction

  function automatic logic ctr_taken(ctr_state_e s);
    return s[1];
  endfunction

endpackage

// File: rtl/sat_ctr.sv
module sat_ctr
  import dir_pred_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       taken_i,
  output ctr_state_e state_o
);

  ctr_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   state_q <= CTR_SNT;
    else if (en_i) state_q <= ctr_next(state_q, taken_i);
  end

  assign state_o = state_q;

  assert_inc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && taken_i && state_q != CTR_ST) |=> (2'(state_q) == 2'($past(state_q)) + 2'd1));

  assert_sat_hi_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && taken_i && state_q == CTR_ST) |=> (state_q == CTR_ST));

  assert_dec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !taken_i && state_q != CTR_SNT) |=> (2'(state_q) == 2'($past(state_q)) - 2'd1));

  assert_sat_lo_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !taken_i && state_q == CTR_SNT) |=> (state_q == CTR_SNT));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(state_q));

endmodule

// File: rtl/ghist_reg.sv
module ghist_reg #(
  parameter int HIST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] hist_o
);

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;

  generate
    if (HIST_W == 1) begin : g_one
      assign hist_d = bit_i;
    end else begin : g_multi
      assign hist_d = {hist_q[HIST_W-2:0], bit_i};

      assert_upper_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shift_i |=> (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0])));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (shift_i) hist_q <= hist_d;
  end

  assign hist_o = hist_q;

  assert_lsb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> (hist_q[0] == $past(bit_i)));

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(hist_q));

endmodule

// File: rtl/pattern_bank.sv
module pattern_bank
  import dir_pred_pkg::*;
#(
  parameter int HIST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_en_i,
  input  logic [HIST_W-1:0] upd_idx_i,
  input  logic              upd_taken_i,
  input  logic [HIST_W-1:0] rd_idx_i,
  output logic              rd_taken_o
);

  localparam int DEPTH = 1 << HIST_W;

  ctr_state_e ctr_state [DEPTH];

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      sat_ctr u_ctr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (upd_en_i && (upd_idx_i == HIST_W'(e))),
        .taken_i (upd_taken_i),
        .state_o (ctr_state[e])
      );
    end
  endgenerate

  assign rd_taken_o = ctr_taken(ctr_state[rd_idx_i]);

endmodule

// File: rtl/dir_pred_ghist.sv
module dir_pred_ghist #(
  parameter int NUM_SLOTS = 4,
  parameter int ID_W      = 3,
  parameter int HIST_W    = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ID_W-1:0] pred_id_i,
  output logic            pred_taken_o,
  input  logic            upd_valid_i,
  input  logic [ID_W-1:0] upd_id_i,
  input  logic            upd_taken_i
);

  localparam logic [ID_W:0] SLOT_LIM = (ID_W + 1)'(NUM_SLOTS);

  logic [HIST_W-1:0]    hist;
  logic [NUM_SLOTS-1:0] slot_taken;
  logic                 upd_ok;
  logic                 pred_ok;

  assign upd_ok  = upd_valid_i && ({1'b0, upd_id_i} < SLOT_LIM);
  assign pred_ok = {1'b0, pred_id_i} < SLOT_LIM;

  // shared history, index taken before the shift
  ghist_reg #(.HIST_W(HIST_W)) u_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (upd_ok),
    .bit_i   (upd_taken_i),
    .hist_o  (hist)
  );

  generate
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      pattern_bank #(.HIST_W(HIST_W)) u_bank (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .upd_en_i    (upd_ok && (upd_id_i == ID_W'(s))),
        .upd_idx_i   (hist),
        .upd_taken_i (upd_taken_i),
        .rd_idx_i    (hist),
        .rd_taken_o  (slot_taken[s])
      );
    end
  endgenerate

  always_comb begin
    pred_taken_o = 1'b0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (pred_id_i == ID_W'(s)) pred_taken_o = slot_taken[s];
    end
  end

  assert_oor_pred_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_ok |-> !pred_taken_o);

  assert_oor_upd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_ok) |=> $stable(hist));

  assert_shared_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_ok |=> (hist[0] == $past(upd_taken_i)));

endmodule

// File: tb/tb_dir_pred_ghist.sv
module tb_dir_pred_ghist;

  localparam int NUM_SLOTS = 4;
  localparam int ID_W      = 3;
  localparam int HIST_W    = 2;
  localparam int NUM_IDS   = 1 << ID_W;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [ID_W-1:0] pred_id_i = '0;
  logic            pred_taken_o;
  logic            upd_valid_i = 1'b0;
  logic [ID_W-1:0] upd_id_i = '0;
  logic            upd_taken_i = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int          mdl_ctr [NUM_SLOTS][1 << HIST_W];
  logic [HIST_W-1:0] mdl_hist;

  always #2 clk_i = ~clk_i;

  dir_pred_ghist #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W), .HIST_W(HIST_W)) dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pred_id_i    (pred_id_i),
    .pred_taken_o (pred_taken_o),
    .upd_valid_i  (upd_valid_i),
    .upd_id_i     (upd_id_i),
    .upd_taken_i  (upd_taken_i)
  );

  function automatic logic exp_pred(int id);
    if (id >= NUM_SLOTS) return 1'b0;          // R9
    return mdl_ctr[id][mdl_hist] >= 2;         // R2
  endfunction

  task automatic mdl_reset();
    for (int s = 0; s < NUM_SLOTS; s++)
      for (int e = 0; e < (1 << HIST_W); e++) mdl_ctr[s][e] = 0;
    mdl_hist = '0;
  endtask

  task automatic mdl_update(int id, logic t);
    if (id >= NUM_SLOTS) return;               // R8
    if (t && mdl_ctr[id][mdl_hist] < 3) mdl_ctr[id][mdl_hist]++;       // R3
    if (!t && mdl_ctr[id][mdl_hist] > 0) mdl_ctr[id][mdl_hist]--;      // R4
    mdl_hist = {mdl_hist[HIST_W-2:0], t};      // R5
  endtask

  task automatic check_one(int id, string tag);
    logic got;
    logic exp;
    pred_id_i = ID_W'(id);
    #1;
    got = pred_taken_o;
    exp = exp_pred(id);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s id=%0d got=%0b exp=%0b", tag, id, got, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int id = 0; id < NUM_IDS; id++) check_one(id, tag);
  endtask

  task automatic do_update(int id, logic t, logic v, string tag);
    upd_valid_i = v;
    upd_id_i    = ID_W'(id);
    upd_taken_i = t;
    @(posedge clk_i);
    #1;
    upd_valid_i = 1'b0;
    if (v) mdl_update(id, t);
    check_all(tag);
  endtask

  task automatic apply_reset();
    @(posedge clk_i);
    #1;
    rst_ni = 1'b0;
    #5;
    rst_ni = 1'b1;
    mdl_reset();
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    mdl_reset();
    #7;
    rst_ni = 1'b1;
    check_all("R1 reset state");

    // R3 saturation: five taken on slot 2 walks the history 00,01,11,11,11
    for (int k = 0; k < 5; k++) do_update(2, 1'b1, 1'b1, "R3 taken saturate");
    // the read at history 11 of slot 2 must now be taken
    check_one(2, "R3 strongly taken read");
    // R4 step down and floor
    for (int k = 0; k < 5; k++) do_update(2, 1'b0, 1'b1, "R4 not-taken saturate");
    // R7 other slots untouched, R6 history shift seen by slot 0
    do_update(0, 1'b1, 1'b1, "R6 shared history");
    do_update(1, 1'b0, 1'b1, "R7 separate tables");
    // R5 index before shift: alternate outcomes on slot 3
    for (int k = 0; k < 8; k++) do_update(3, k[0], 1'b1, "R5 pre-shift index");
    // R8 out-of-range updates are ignored
    for (int k = 4; k < NUM_IDS; k++) do_update(k, 1'b1, 1'b1, "R8 out-of-range update");
    // R10 strobe low changes nothing
    do_update(1, 1'b1, 1'b0, "R10 strobe low");
    do_update(2, 1'b0, 1'b0, "R10 strobe low");

    // R2 mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      int id;
      logic t;
      logic v;
      id = int'($urandom_range(NUM_IDS - 1));
      t  = ($urandom_range(3) != 0);
      v  = ($urandom_range(7) != 0);
      if (n % 500 < 250) t = ($urandom_range(1) == 1);
      do_update(id, t, v, "R2 random");
    end

    // R1 reset in mid-run
    apply_reset();
    check_all("R1 reset after traffic");
    // R9 out-of-range reads after training
    for (int k = 0; k < 4; k++) do_update(k, 1'b1, 1'b1, "R9 training");
    check_all("R9 out-of-range read");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule